// File: doc/BRIEF.md
# Dual-Channel Serial Converter Front End

This block is the digital input stage of a two-channel 12-bit converter. A host writes codes over a three-wire serial port with a serial clock, a data line and an active-low select. Each bit enters a 24-bit chain that holds the codes for both channels. A separate active-low update strobe copies the whole chain into two 12-bit latches. The latches drive the parallel code buses of channel A and channel B. A serial output with open-drain behaviour presents the bit that leaves the far end of the chain. Several devices can therefore be chained together, and the host can read back the bits it wrote before.

All serial inputs arrive as plain data in a faster system clock domain. Each one passes through a two-flop synchronizer. The serial clock and the update strobe then go through edge detectors that give single-cycle pulses. A three-state controller sequences the block:

- ST_IDLE: not selected.
- ST_SELECT: selected, shifting in and driving the output.
- ST_LOAD: one cycle in which the latches take the chain.

The transitions are:

- T_SEL: ST_IDLE to ST_SELECT when the synced select goes low.
- T_DESEL: ST_SELECT to ST_IDLE when the synced select goes high.
- T_UPD: ST_IDLE to ST_LOAD on a falling update strobe while deselected.
- T_DONE: ST_LOAD to ST_IDLE.
- T_DONE_SEL: ST_LOAD to ST_SELECT if select is already low.

Top module: `dual_dac_front`

## Requirements
- R1: After reset, both code buses read 0 and `so_pull_low` is 0.
- R2: While selected, each rising `ser_clk` edge shifts `ser_data` into the chain, MSB first. After a 24-bit frame and an update, `code_a` holds the first 12 bits and `code_b` holds the last 12.
- R3: `ser_clk` edges while `sel_n` is high leave the chain unchanged.
- R4: A low pulse on `upd_n` while `sel_n` is low does not change either code bus.
- R5: While deselected, the serial output is released, so `so_pull_low` is 0.
- R6: While selected, the output presents the chain's top bit. A value of 1 leaves `so_pull_low` at 0, and a value of 0 sets it to 1. The output takes a new bit only after a falling `ser_clk` edge. The bits read before each rising edge of a frame are therefore the 24 bits previously held in the chain, oldest first.
- R7: Two devices cascaded through the serial output, with a pull-up, accept a 48-bit frame. The downstream device keeps the first 24 bits and the upstream device keeps the last 24.
- R8: One update pulse while deselected loads both code buses from the chain in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `ser_clk` |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data input |
| sel_n | input | 1 | Active-low device select |
| upd_n | input | 1 | Active-low latch update strobe |
| so_pull_low | output | 1 | Serial output pull-down enable (1 pulls the line low) |
| code_a | output | 12 | Latched code of channel A |
| code_b | output | 12 | Latched code of channel B |

## Verification
Call the first system clock edge that samples an input change edge k. A rising serial clock shifts the chain at edge k+2. A falling serial clock, or entry into selection, changes the serial output at edge k+2. A falling update strobe moves the controller to ST_LOAD at edge k+2, and the code buses change at edge k+3. The assertions use exactly these depths. The bench holds every serial level for 8 system cycles and samples only after such waits, so each result has settled before it is read. The bench samples the serial output just before each rising edge, where a downstream device would take it.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int CODE_W  = 12;
    localparam int NUM_CH  = 2;
    localparam int CHAIN_W = CODE_W * NUM_CH;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_LOAD   = 2'd2
    } fe_state_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dacfe_edge.sv
module dacfe_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/dacfe_chain.sv
module dacfe_chain #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             launch,
    output logic [WIDTH-1:0] word,
    output logic             out_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[WIDTH-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_bit <= 1'b1;
        end else if (launch) begin
            out_bit <= word[WIDTH-1];
        end
    end
endmodule

// File: rtl/dacfe_latch.sv
module dacfe_latch #(
    parameter int CODE_W = 12,
    parameter int NUM_CH = 2,
    localparam int CHAIN_W = CODE_W * NUM_CH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CHAIN_W-1:0] word,
    output logic [CODE_W-1:0]  codes [NUM_CH]
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    codes[g] <= '0;
            else if (load) codes[g] <= word[(NUM_CH-1-g)*CODE_W +: CODE_W];
        end
    end
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              sel_n,
    input  logic              upd_n,
    output logic              so_pull_low,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    // synced order: {ser_clk, ser_data, sel_n, upd_n}
    localparam logic [3:0] SYNC_RST = 4'b0011;

    logic [3:0] sync_q;
    logic       clk_s, data_s, sel_s, upd_s;
    logic       clk_rise, clk_fall, upd_rise_unused, upd_fall;
    fe_state_t  state_q, state_d;
    logic       shift_en, launch, load_en, drive_en;
    logic [CHAIN_W-1:0] word;
    logic       out_bit;
    logic [CODE_W-1:0]  codes [NUM_CH];

    dacfe_sync #(.WIDTH(4), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_data, sel_n, upd_n}),
        .q     (sync_q)
    );
    assign {clk_s, data_s, sel_s, upd_s} = sync_q;

    dacfe_edge #(.RST_VAL(1'b0)) u_clk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (clk_s),
        .rise  (clk_rise),
        .fall  (clk_fall)
    );

    dacfe_edge #(.RST_VAL(1'b1)) u_upd_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (upd_s),
        .rise  (upd_rise_unused),
        .fall  (upd_fall)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!sel_s)        state_d = ST_SELECT;   // T_SEL
                else if (upd_fall) state_d = ST_LOAD;     // T_UPD
            end
            ST_SELECT: begin
                if (sel_s)         state_d = ST_IDLE;     // T_DESEL
            end
            ST_LOAD: begin
                state_d = sel_s ? ST_IDLE : ST_SELECT;    // T_DONE / T_DONE_SEL
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        shift_en = 1'b0;
        launch   = 1'b0;
        load_en  = 1'b0;
        drive_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                launch = !sel_s;
            end
            ST_SELECT: begin
                drive_en = 1'b1;
                shift_en = !sel_s && clk_rise;
                launch   = !sel_s && clk_fall;
            end
            ST_LOAD: begin
                load_en = 1'b1;
                launch  = !sel_s;
            end
            default: ;
        endcase
    end

    dacfe_chain #(.WIDTH(CHAIN_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (data_s),
        .launch   (launch),
        .word     (word),
        .out_bit  (out_bit)
    );

    dacfe_latch #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_en),
        .word  (word),
        .codes (codes)
    );

    assign so_pull_low = drive_en && !out_bit;
    assign code_a      = codes[0];
    assign code_b      = codes[1];
endmodule

// File: rtl/dual_dac_front_chk.sv
module dual_dac_front_chk
    import dacfe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ser_clk,
    input logic              sel_n,
    input logic              upd_n,
    input logic              so_pull_low,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b
);
    // R5: three sampled cycles deselected -> output released
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_n, 1) && $past(sel_n, 2) && $past(sel_n, 3)) |-> !so_pull_low);

    // R8: a code change follows a falling update strobe sampled four edges back
    p_update_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(code_a) || !$stable(code_b)) |-> (!$past(upd_n, 4) && $past(upd_n, 5)));

    // R4: a code change never follows an update strobe taken while selected
    p_sel_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(code_a) || !$stable(code_b)) |-> $past(sel_n, 4));

    // R6: while selection is steady, the output moves only after a falling serial clock
    p_fall_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(so_pull_low) && !$past(sel_n, 3) && !$past(sel_n, 4))
        |-> (!$past(ser_clk, 3) && $past(ser_clk, 4)));
endmodule

bind dual_dac_front dual_dac_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk     (ser_clk),
    .sel_n       (sel_n),
    .upd_n       (upd_n),
    .so_pull_low (so_pull_low),
    .code_a      (code_a),
    .code_b      (code_b)
);

// File: tb/test_dual_dac_front.sv
module test_dual_dac_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        sel_n = 1'b1;
    logic        upd_n = 1'b1;
    logic        up_pull, dn_pull;
    logic [11:0] up_a, up_b, dn_a, dn_b;
    logic        link;
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    // pull-up on the link between the devices
    assign link = ~up_pull;

    dual_dac_front i_dual_dac_front (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .sel_n(sel_n), .upd_n(upd_n), .so_pull_low(up_pull),
        .code_a(up_a), .code_b(up_b)
    );

    dual_dac_front i_dual_dac_front_dn (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(link),
        .sel_n(sel_n), .upd_n(upd_n), .so_pull_low(dn_pull),
        .code_a(dn_a), .code_b(dn_b)
    );

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic frame(input int n, input logic [47:0] bits, output logic [47:0] rb);
        rb = '0;
        sel_n = 1'b0;
        waitc(8);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            waitc(8);
            rb[i] = ~up_pull;
            ser_clk = 1'b1;
            waitc(8);
            ser_clk = 1'b0;
        end
        waitc(8);
        sel_n = 1'b1;
        waitc(8);
    endtask

    task automatic pulse_upd();
        upd_n = 1'b0;
        waitc(8);
        upd_n = 1'b1;
        waitc(8);
    endtask

    task automatic t_reset();
        chk("R1 code_a", {12'h0, up_a}, 24'h0);
        chk("R1 code_b", {12'h0, up_b}, 24'h0);
        chk("R1 pull", {23'h0, up_pull}, 24'h0);
    endtask

    task automatic t_single();
        logic [47:0] rb;
        frame(24, {24'h0, 24'hA5C3E1}, rb);
        chk("R6 readback after reset", rb[23:0], 24'h000000);
        chk("R2 not yet loaded", {up_a, up_b}, 24'h0);
        pulse_upd();
        chk("R2 code_a first bits", {12'h0, up_a}, 24'h000A5C);
        chk("R2 code_b last bits", {12'h0, up_b}, 24'h0003E1);
    endtask

    task automatic t_readback();
        logic [47:0] rb;
        frame(24, {24'h0, 24'h123456}, rb);
        chk("R6 readback of previous frame", rb[23:0], 24'hA5C3E1);
        pulse_upd();
        chk("R2 second frame", {up_a, up_b}, 24'h123456);
    endtask

    task automatic t_desel_clk();
        ser_data = 1'b1;
        for (int i = 0; i < 5; i++) begin
            waitc(8);
            ser_clk = 1'b1;
            chk("R5 released while deselected", {23'h0, up_pull}, 24'h0);
            waitc(8);
            ser_clk = 1'b0;
        end
        waitc(8);
        pulse_upd();
        chk("R3 codes after deselected clocks", {up_a, up_b}, 24'h123456);
    endtask

    task automatic t_sel_load();
        logic [47:0] rb;
        frame(24, {24'h0, 24'h7FF800}, rb);
        chk("R3 chain kept through deselected clocks", rb[23:0], 24'h123456);
        sel_n = 1'b0;
        waitc(8);
        pulse_upd();
        chk("R4 update ignored while selected", {up_a, up_b}, 24'h123456);
        sel_n = 1'b1;
        waitc(8);
        pulse_upd();
        chk("R8 both channels loaded", {up_a, up_b}, 24'h7FF800);
    endtask

    task automatic t_cascade();
        logic [47:0] rb;
        frame(48, {24'hABCDEF, 24'h13579B}, rb);
        pulse_upd();
        chk("R7 upstream keeps last 24", {up_a, up_b}, 24'h13579B);
        chk("R7 downstream keeps first 24", {dn_a, dn_b}, 24'hABCDEF);
        chk("R5 released after frame", {22'h0, up_pull, dn_pull}, 24'h0);
    endtask

    initial begin
        waitc(4);
        t_reset();
        rst_n = 1'b1;
        waitc(4);
        t_reset();
        t_single();
        t_readback();
        t_desel_clk();
        t_sel_load();
        t_cascade();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule